// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts timebase ticks over a period picked from four power-of-two lengths. Each time a period runs out without software intervening, a two-bit state held in the status register steps one rung up a ladder. The first expiry arms a flag. The second raises a level interrupt, provided the interrupt is enabled. The third records the configured reset kind in status and fires a single-cycle request on one of three reset outputs.

Software programs the control register to choose the period, the reset kind and the interrupt enable. Every control write also restarts the period from zero. Software acknowledges events by writing ones to the status register. A simple write strobe with a register select reaches both registers, and a combinational read port returns either one.

Once the ladder reaches its top and the reset request has fired, the counter stops. It runs again only after the next control write.

Top module: `wdt_ladder`

## Requirements
- R1: The period ends on the tick that sets bit BASE_BIT+STEP*p of the period counter for the first time since it was cleared, where p is control bits 31:30. That is 2^(BASE_BIT+STEP*p) ticks after a restart. The defaults select 2^17, 2^21, 2^25 and 2^29 ticks.
- R2: If status bits 31:30 hold 00 or 01 when a period ends, status bit 31 becomes 1 and a new period begins.
- R3: If status bits 31:30 hold 10 when a period ends, status bit 30 becomes 1 and a new period begins.
- R4: `wdt_irq` is high exactly while status bit 30 and control bit 27 (interrupt enable) are both 1.
- R5: If status bits 31:30 hold 11 when a period ends, control bits 29:28 are copied over status bits 29:28. The counter then stops until the next control write.
- R6: When the R5 expiry occurs, a kind value of 1, 2 or 3 gives a one-cycle pulse on `rst_core`, `rst_chip` or `rst_sys` respectively, starting at the same clock edge that updates status. A kind value of 0 gives no pulse. At most one of these outputs is high at any time.
- R7: A status write (`wr_sel`=1) clears every status bit among 31:26 that is 1 in `wr_data`, and no other bit changes. If a clear and an expiry land in the same cycle, the clear wins for the bits it names.
- R8: A control write (`wr_sel`=0) stores `wr_data` bits 31:22. Control bits 21:0 always read as zero. `rd_sel`=0 reads control and `rd_sel`=1 reads status.
- R9: A control write clears the period counter, restarts counting, and suppresses any expiry in that same cycle.
- R10: After reset, both registers read zero, the period counter is zero and counting, and all outputs are low.
- R11: The period counter advances only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 32 | Read data of the selected register |
| wdt_irq | output | 1 | Watchdog interrupt (level) |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is 01 in status bits 31:30. No expiry ever produces it. The bench gets there by climbing the ladder to 11, letting the counter stop at the top, and then clearing only bit 31. It then confirms that the stopped counter leaves that state alone, and that after a control write the next expiry moves 01 back to 11 through the R2 path.

The bench also places a status clear in the very cycle of an expiry, to show that the clear wins. It shortens the period through parameters (base bit 4, step 2) so that all four period selections and full ladder climbs fit in a short run.

// File: rtl/wdt_ladder_pkg.sv
package wdt_ladder_pkg;

  // Control register upper field, bits 31:22
  typedef struct packed {
    logic [1:0] period;    // 31:30
    logic [1:0] rst_kind;  // 29:28
    logic       irq_en;    // 27
    logic [4:0] spare;     // 26:22, stored only
  } ctrl_t;

  typedef enum logic [1:0] {
    LAD_IDLE  = 2'b00,
    LAD_LOW   = 2'b01,
    LAD_ARMED = 2'b10,
    LAD_TOP   = 2'b11
  } ladder_e;

  // Counter bit whose first rise ends a period
  function automatic int unsigned tap_index(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned sel);
    return base + step * sel;
  endfunction

  // Status bits 31:28 after one expiry
  function automatic logic [3:0] ladder_step(input logic [3:0] st,
                                             input logic [1:0] kind);
    logic [3:0] r;
    r = st;
    case (ladder_e'(st[3:2]))
      LAD_IDLE, LAD_LOW: r[3] = 1'b1;
      LAD_ARMED:         r[2] = 1'b1;
      default:           r[1:0] = kind;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
  parameter int unsigned BASE_BIT = 17,
  parameter int unsigned STEP     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] period_sel,
  output logic       expire
);
  import wdt_ladder_pkg::*;

  localparam int unsigned NSEL  = 4;
  localparam int unsigned CNT_W = tap_index(BASE_BIT, STEP, NSEL - 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [NSEL-1:0]  rise;

  assign cnt_nxt = cnt + 1'b1;

  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    localparam int unsigned B = tap_index(BASE_BIT, STEP, i);
    assign rise[i] = cnt_nxt[B] & ~cnt[B];
  end

  assign expire = tick & run & ~restart & rise[period_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || expire) cnt <= '0;
    else if (tick && run)      cnt <= cnt_nxt;
  end

  // R11: no tick and no restart leave the counter unchanged
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));

  // R9: the cycle after a restart cannot end a period
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expire);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_ladder_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       st_wr,
  input  logic [9:0] wr_hi,
  input  logic       expire,
  output ctrl_t      ctrl,
  output logic [3:0] st,
  output logic       run,
  output logic       final_hit,
  output logic       irq_step
);

  logic [3:0] st_adv;
  logic [3:0] st_nxt;

  assign final_hit = expire & (st[3:2] == 2'b11);
  assign irq_step  = expire & (st[3:2] == 2'b10);
  assign st_adv    = expire ? ladder_step(st, ctrl.rst_kind) : st;
  assign st_nxt    = st_wr ? (st_adv & ~wr_hi[9:6]) : st_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      st   <= '0;
      run  <= 1'b1;
    end else begin
      st <= st_nxt;
      if (ctrl_wr) begin
        ctrl <= ctrl_t'(wr_hi);
        run  <= 1'b1;
      end else if (final_hit) begin
        run  <= 1'b0;
      end
    end
  end

  // R7: bits named by a status write are zero afterwards
  assert_w1c_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((st & $past(wr_hi[9:6])) == 4'b0));

  // R2: expiry from 00/01 sets bit 31
  assert_arm_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !st[3] && !st_wr) |=> st[3]);

  // R5: reset kind captured and counting stopped
  assert_kind_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (final_hit && !st_wr) |=> (st[1:0] == $past(ctrl.rst_kind)) && !run);

endmodule

// File: rtl/wdt_rst_req.sv
module wdt_rst_req (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       final_hit,
  input  logic [1:0] kind,
  output logic [2:0] req
);

  for (genvar i = 0; i < 3; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (!rst_n) req[i] <= 1'b0;
      else        req[i] <= final_hit && (kind == 2'(i + 1));
    end
  end

  // R6: one-hot request, single-cycle pulse
  assert_req_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req != 3'b0) |=> (req == 3'b0));

endmodule

// File: rtl/wdt_ladder.sv
module wdt_ladder #(
  parameter int unsigned BASE_BIT = 17,
  parameter int unsigned STEP     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        wdt_irq,
  output logic        rst_core,
  output logic        rst_chip,
  output logic        rst_sys
);
  import wdt_ladder_pkg::*;

  localparam int unsigned CTRL_LO = 22;
  localparam int unsigned ST_LO   = 28;

  ctrl_t      ctrl;
  logic [3:0] st;
  logic       run;
  logic       expire;
  logic       final_hit;
  logic       irq_step;
  logic       ctrl_wr;
  logic       st_wr;
  logic [2:0] req;

  assign ctrl_wr = wr_en & ~wr_sel;
  assign st_wr   = wr_en &  wr_sel;

  wdt_period_cnt #(.BASE_BIT(BASE_BIT), .STEP(STEP)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (run),
    .restart    (ctrl_wr),
    .period_sel (ctrl.period),
    .expire     (expire)
  );

  wdt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .st_wr     (st_wr),
    .wr_hi     (wr_data[31:CTRL_LO]),
    .expire    (expire),
    .ctrl      (ctrl),
    .st        (st),
    .run       (run),
    .final_hit (final_hit),
    .irq_step  (irq_step)
  );

  wdt_rst_req u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .final_hit (final_hit),
    .kind      (ctrl.rst_kind),
    .req       (req)
  );

  assign rd_data  = rd_sel ? {st, {ST_LO{1'b0}}} : {ctrl, {CTRL_LO{1'b0}}};
  assign wdt_irq  = st[2] & ctrl.irq_en;
  assign rst_core = req[0];
  assign rst_chip = req[1];
  assign rst_sys  = req[2];

  // R4: the interrupt rises only after an armed expiry or a control write
  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> $past(irq_step || ctrl_wr));

endmodule

// File: tb/wdt_ladder_test.sv
module wdt_ladder_test;
  localparam int unsigned BASE = 4;
  localparam int unsigned STP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        wdt_irq, rst_core, rst_chip, rst_sys;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wdt_ladder #(.BASE_BIT(BASE), .STEP(STP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .wdt_irq(wdt_irq),
    .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
  );

  function automatic int period_len(input int sel);
    return 1 << (BASE + STP * sel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic chk_st(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic chk_req(input string req, input logic [2:0] exp);
    chk(req, {29'b0, rst_sys, rst_chip, rst_core}, {29'b0, exp});
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input logic with_tick = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wr_data = '0;
  endtask

  task automatic fresh(input logic [31:0] c);
    wr(1'b1, 32'hFC00_0000);
    wr(1'b0, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R10 ctrl", v, 32'h0);
    rd(1'b1, v); chk("R10 status", v, 32'h0);
    chk("R10 irq", {31'b0, wdt_irq}, 32'h0);
    chk_req("R10 req", 3'b000);
    do_ticks(period_len(0) - 1);
    chk_st("R10 counter starts at zero", 32'h0);
    do_ticks(1);
    chk_st("R10 first period", 32'h8000_0000);
  endtask

  task automatic t_ctrl_mask();
    logic [31:0] v;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R8 ctrl mask", v, 32'hFFC0_0000);
    wr(1'b0, 32'h0155_AAAA);
    rd(1'b0, v); chk("R8 ctrl low bits", v, 32'h0140_0000);
  endtask

  task automatic t_period(input int sel);
    fresh(32'(sel) << 30);
    do_ticks(period_len(sel) - 1);
    chk_st("R1 before boundary", 32'h0);
    do_ticks(1);
    chk_st("R1 R2 at boundary", 32'h8000_0000);
  endtask

  task automatic t_ladder(input int kind, input logic ie);
    logic [31:0] top;
    logic [2:0]  pulse;
    top   = 32'hC000_0000 | (32'(kind) << 28);
    pulse = (kind == 0) ? 3'b000 : 3'(1 << (kind - 1));
    fresh((32'(kind) << 28) | (32'(ie) << 27));
    do_ticks(16);
    chk_st("R2 arm", 32'h8000_0000);
    chk("R4 no irq when armed", {31'b0, wdt_irq}, 32'h0);
    do_ticks(16);
    chk_st("R3 second step", 32'hC000_0000);
    chk("R4 irq level", {31'b0, wdt_irq}, {31'b0, ie});
    do_ticks(16);
    chk_st("R5 kind latched", top);
    chk_req("R6 pulse", pulse);
    idle(1);
    chk_req("R6 pulse ends", 3'b000);
    // stopped: clear bit 31 to reach 01 and confirm nothing moves
    wr(1'b1, 32'h8000_0000);
    do_ticks(40);
    chk_st("R5 counter stopped", top & 32'h7FFF_FFFF);
    chk_req("R6 no pulse while stopped", 3'b000);
    wr(1'b0, (32'(kind) << 28) | (32'(ie) << 27));
    do_ticks(16);
    chk_st("R2 from 01", top);
    do_ticks(16);
    chk_req("R6 pulse again", pulse);
  endtask

  task automatic t_irq_en();
    fresh(32'h0800_0000);
    do_ticks(32);
    chk("R4 irq set", {31'b0, wdt_irq}, 32'h1);
    wr(1'b0, 32'h0);
    chk("R4 enable cleared", {31'b0, wdt_irq}, 32'h0);
    wr(1'b0, 32'h0800_0000);
    chk("R4 enable again", {31'b0, wdt_irq}, 32'h1);
    wr(1'b1, 32'h4000_0000);
    chk("R4 bit30 cleared", {31'b0, wdt_irq}, 32'h0);
  endtask

  task automatic t_w1c();
    fresh(32'h0);
    do_ticks(32);
    chk_st("R7 setup", 32'hC000_0000);
    wr(1'b1, 32'h03FF_FFFF);
    chk_st("R7 low bits ignored", 32'hC000_0000);
    wr(1'b1, 32'h8000_0000);
    chk_st("R7 clear bit31", 32'h4000_0000);
    fresh(32'h0);
    do_ticks(15);
    wr(1'b1, 32'h8000_0000, 1'b1);
    chk_st("R7 clear beats expiry", 32'h0);
  endtask

  task automatic t_restart();
    fresh(32'h0);
    do_ticks(10);
    wr(1'b0, 32'h0, 1'b1);
    do_ticks(10);
    chk_st("R9 restart delays expiry", 32'h0);
    idle(50);
    chk_st("R11 no tick no count", 32'h0);
    do_ticks(5);
    chk_st("R9 R11 before new boundary", 32'h0);
    do_ticks(1);
    chk_st("R9 new boundary", 32'h8000_0000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_mask();
    for (int s = 0; s < 4; s++) t_period(s);
    t_ladder(0, 1'b1);
    t_ladder(1, 1'b0);
    t_ladder(2, 1'b1);
    t_ladder(3, 1'b1);
    t_irq_en();
    t_w1c();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule